// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block runs on a slow clock and decides when an external undervoltage comparator is powered and when its answer counts. A single 32-bit mode register holds three settings. The first is a 4-bit threshold code, passed straight to the comparator's reference selector. The codes run from 1.9 V at code 0 to 3.4 V at code 15, in 0.1 V steps. The second is a sampling mode, which is off, continuous, or a one-cycle strobe every 32, 256 or 2048 slow-clock cycles. The third is a pair of enables that route a detection to an active-low core reset, to an interrupt, or to both.

The comparator result passes through a synchronizer. A qualified detection sets a sticky status flag, which a read of the status word clears. The interrupt follows that flag, gated by its enable. A core reset, once raised, lasts a fixed minimum number of cycles. After that it drops at the first clean sample, or as soon as sampling is turned off.

Top module: `supmon_ctrl`

## Requirements
- R1: Mode register bits 3:0 (threshold code) appear unchanged on `cmp_level`.
- R2: Mode bits 10:8 select sampling. Code 0 keeps `cmp_en` low. Code 1 keeps it high. Codes 2, 3 and 4 raise it for exactly one cycle in every 32, 256 or 2048. Every mode write restarts the count, so the first strobe lands in cycle P-1 after the write edge, where cycle 0 is the one right after it.
- R3: Sampling codes 5, 6 and 7 behave as code 0: `cmp_en` stays low and no detection occurs.
- R4: When `reg_sel`=0, `rdata` returns the mode register with every unused bit reading zero. The used bits are 3:0, 10:8, 12 and 13. When `reg_sel`=1, `rdata` returns the status flag in bit 0 and zeros elsewhere.
- R5: `cmp_trip` is synchronized through two flops. A detection is a synchronized trip seen while `cmp_en` is high. With the input held, the flag therefore rises three edges after `cmp_trip` rises in continuous mode.
- R6: A detection sets `trip_flag`. The flag stays set until a read with `reg_sel`=1 and `rd_en`=1. If a detection and a read fall in the same cycle, the detection wins.
- R7: `irq` is high exactly when the flag is set and mode bit 13 is 1.
- R8: With mode bit 12 set, a detection drives `core_rst_n` low for at least 4 cycles. With bit 12 clear, a detection never lowers it.
- R9: After the minimum hold, `core_rst_n` rises at the first sample without a synchronized trip, or at once if sampling is off. A detection during the hold restarts the hold.
- R10: After reset, the mode register is zero, the flag is clear, `irq`=0, `cmp_en`=0 and `core_rst_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the status word |
| wr_en | input | 1 | Write strobe for the mode register (when reg_sel=0) |
| rd_en | input | 1 | Read strobe; clears the status flag when reg_sel=1 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| cmp_en | output | 1 | Comparator power/enable |
| cmp_level | output | 4 | Threshold code to the comparator |
| cmp_trip | input | 1 | Asynchronous comparator result, 1 = undervoltage |
| core_rst_n | output | 1 | Active-low core reset request |
| irq | output | 1 | Interrupt request |
| trip_flag | output | 1 | Sticky detection flag |

## Verification
The bench counts strobes and measures the first strobe's offset after a write for every sampling code. A counter with an off-by-one terminal value, or one that ignores the restart, shows up as a wrong count or a wrong first position. Reserved codes that fall through to a duty mode would show strobes where none are expected. A trip held across a duty window is checked one cycle either side of the window, so a design that samples outside the window sets the flag too early. The core reset is timed edge by edge, both for a single pulse and for a held trip. A short hold, a missed reload or a release without a clean sample moves the rising edge.

// File: rtl/supmon_pkg.sv
`timescale 1ns/1ps
package supmon_pkg;

   typedef enum logic [1:0] {
      SMP_IDLE = 2'd0,
      SMP_CONT = 2'd1,
      SMP_DUTY = 2'd2
   } smp_run_e;

   typedef struct packed {
      logic       irq_en;
      logic       rst_en;
      logic [2:0] smp;
      logic [3:0] thr;
   } mode_t;

   function automatic mode_t unpack_mode(input logic [31:0] w);
      mode_t m;
      m.thr    = w[3:0];
      m.smp    = w[10:8];
      m.rst_en = w[12];
      m.irq_en = w[13];
      return m;
   endfunction

   function automatic logic [31:0] pack_mode(input mode_t m);
      logic [31:0] w;
      w        = '0;
      w[3:0]   = m.thr;
      w[10:8]  = m.smp;
      w[12]    = m.rst_en;
      w[13]    = m.irq_en;
      return w;
   endfunction

endpackage

// File: rtl/supmon_sync.sv
`timescale 1ns/1ps
module supmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial assert (STAGES >= 2) else $error("supmon_sync: STAGES must be at least 2");

   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[0] <= 1'b0;
      else        q[0] <= din;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[g] <= 1'b0;
         else        q[g] <= q[g-1];
      end
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/supmon_sched.sv
`timescale 1ns/1ps
module supmon_sched
   import supmon_pkg::*;
#(
   parameter int PER_A = 32,
   parameter int PER_B = 256,
   parameter int PER_C = 2048
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] smp,
   output logic       cmp_en,
   output logic       mon_on
);
   localparam int CNT_W = $clog2(PER_C);
   localparam logic [CNT_W-1:0] LAST_A = CNT_W'(PER_A - 1);
   localparam logic [CNT_W-1:0] LAST_B = CNT_W'(PER_B - 1);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PER_C - 1);

   initial assert (PER_A >= 2 && PER_A < PER_B && PER_B < PER_C)
      else $error("supmon_sched: periods must be increasing and at least 2");

   smp_run_e         run;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      run  = SMP_IDLE;
      last = LAST_A;
      case (smp)
         3'd1: run = SMP_CONT;
         3'd2: begin run = SMP_DUTY; last = LAST_A; end
         3'd3: begin run = SMP_DUTY; last = LAST_B; end
         3'd4: begin run = SMP_DUTY; last = LAST_C; end
         default: run = SMP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (restart)           cnt <= '0;
      else if (run == SMP_DUTY)   cnt <= (cnt == last) ? '0 : cnt + 1'b1;
      else                        cnt <= '0;
   end

   assign cmp_en = (run == SMP_CONT) || ((run == SMP_DUTY) && (cnt == last));
   assign mon_on = (run != SMP_IDLE);

   // R2: a duty strobe is a single cycle wide unless the mode is rewritten
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (run == SMP_DUTY && cmp_en && !restart) |=> !cmp_en);
endmodule

// File: rtl/supmon_resp.sv
`timescale 1ns/1ps
module supmon_resp #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic trip_s,
   input  logic mon_on,
   input  logic rst_en,
   input  logic irq_en,
   input  logic clr,
   output logic status,
   output logic irq,
   output logic core_rst_n
);
   localparam int HW = $clog2(HOLD + 1);

   initial assert (HOLD >= 1) else $error("supmon_resp: HOLD must be at least 1");

   logic          detect;
   logic          act;
   logic [HW-1:0] hold;

   assign detect = sample && trip_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status <= 1'b0;
      else if (detect) status <= 1'b1;
      else if (clr)    status <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         hold <= '0;
      end else if (detect && rst_en) begin
         act  <= 1'b1;
         hold <= HW'(HOLD - 1);
      end else if (hold != '0) begin
         hold <= hold - 1'b1;
      end else if (act && ((sample && !trip_s) || !mon_on)) begin
         act  <= 1'b0;
      end
   end

   assign irq        = status && irq_en;
   assign core_rst_n = !act;

   // checker state: length of the current low period, saturating
   logic [HW:0] low_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_len <= '0;
      else if (!act)                    low_len <= '0;
      else if (low_len < (HW+1)'(HOLD)) low_len <= low_len + 1'b1;
   end

   // R6: flag survives until a clearing read
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !clr) |=> status);
   // R8: no reset response while the enable is clear
   a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_en && core_rst_n) |=> core_rst_n);
   // R8: minimum hold length
   a_r8_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n) |-> (low_len >= (HW+1)'(HOLD)));
   // R9: once low, stays low for the next cycle
   a_r9_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst_n) |=> !core_rst_n);
endmodule

// File: rtl/supmon_ctrl.sv
`timescale 1ns/1ps
module supmon_ctrl
   import supmon_pkg::*;
#(
   parameter int PER_A       = 32,
   parameter int PER_B       = 256,
   parameter int PER_C       = 2048,
   parameter int HOLD        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_sel,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        cmp_en,
   output logic [3:0]  cmp_level,
   input  logic        cmp_trip,
   output logic        core_rst_n,
   output logic        irq,
   output logic        trip_flag
);
   mode_t mode_q;
   logic  mode_wr;
   logic  stat_rd;
   logic  trip_s;
   logic  mon_on;
   logic  unused_wbits;

   assign mode_wr      = wr_en && !reg_sel;
   assign stat_rd      = rd_en && reg_sel;
   assign unused_wbits = ^{wdata[31:14], wdata[11], wdata[7:4]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= unpack_mode(wdata);
   end

   assign rdata     = reg_sel ? {31'd0, trip_flag} : pack_mode(mode_q);
   assign cmp_level = mode_q.thr;

   supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cmp_trip),
      .dout (trip_s)
   );

   supmon_sched #(.PER_A(PER_A), .PER_B(PER_B), .PER_C(PER_C)) u_sched (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(mode_wr),
      .smp    (mode_q.smp),
      .cmp_en (cmp_en),
      .mon_on (mon_on)
   );

   supmon_resp #(.HOLD(HOLD)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (cmp_en),
      .trip_s    (trip_s),
      .mon_on    (mon_on),
      .rst_en    (mode_q.rst_en),
      .irq_en    (mode_q.irq_en),
      .clr       (stat_rd),
      .status    (trip_flag),
      .irq       (irq),
      .core_rst_n(core_rst_n)
   );

   // R3: reserved and off codes never strobe the comparator
   a_r3_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.smp == 3'd0 || mode_q.smp >= 3'd5) |-> !cmp_en);
   // R5: the flag can only rise after a strobed cycle
   a_r5_window_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en) |=> !$rose(trip_flag));
endmodule

// File: tb/supmon_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        cmp_en;
   logic [3:0]  cmp_level;
   logic        cmp_trip = 1'b0;
   logic        core_rst_n;
   logic        irq;
   logic        trip_flag;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   supmon_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .cmp_en(cmp_en), .cmp_level(cmp_level),
      .cmp_trip(cmp_trip), .core_rst_n(core_rst_n), .irq(irq), .trip_flag(trip_flag)
   );

   // sampling code, threshold, expected strobes in 4096 cycles, first strobe index
   localparam int NV = 8;
   localparam int VCODE  [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
   localparam int VTHR   [NV] = '{0, 15, 7, 9, 3, 12, 5, 10};
   localparam int VCNT   [NV] = '{0, 4096, 128, 16, 2, 0, 0, 0};
   localparam int VFIRST [NV] = '{-1, 0, 31, 255, 2047, -1, -1, -1};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int thr, input int smp, input bit rst, input bit ien);
      return {16'hA5A5, 2'b00, ien, rst, 1'b1, 3'(smp), 4'hF, 4'(thr)};
   endfunction

   function automatic logic [31:0] expw(input int thr, input int smp, input bit rst, input bit ien);
      return {18'd0, ien, rst, 1'b0, 3'(smp), 4'h0, 4'(thr)};
   endfunction

   // leaves the caller at the falling edge right after the write edge
   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b0; wr_en = 1'b1; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_status(output logic [31:0] v);
      @(negedge clk);
      reg_sel = 1'b1; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      cyc(3);
      // R10 reset state
      check("R10 core_rst_n", 32'(core_rst_n), 32'd1);
      check("R10 irq", 32'(irq), 32'd0);
      check("R10 cmp_en", 32'(cmp_en), 32'd0);
      check("R10 flag", 32'(trip_flag), 32'd0);
      check("R10 mode", rdata, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      cyc(2);
      check("R10 after release cmp_en", 32'(cmp_en), 32'd0);

      // vector walk: R1 R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         int cnt;
         int first;
         cnt = 0; first = -1;
         wr(mk(VTHR[i], VCODE[i], 1'b0, 1'b0));
         check("R4 readback", rdata, expw(VTHR[i], VCODE[i], 1'b0, 1'b0));
         check("R1 cmp_level", 32'(cmp_level), 32'(VTHR[i]));
         for (int k = 0; k < 4096; k++) begin
            if (cmp_en) begin
               cnt++;
               if (first < 0) first = k;
            end
            @(negedge clk);
         end
         if (VCODE[i] >= 5) begin
            check("R3 reserved strobes", 32'(cnt), 32'(VCNT[i]));
         end else begin
            check("R2 strobe count", 32'(cnt), 32'(VCNT[i]));
            check("R2 first strobe", 32'(first), 32'(VFIRST[i]));
         end
      end

      // R5 R6 R7 continuous, interrupt only; R8 reset path gated off
      wr(mk(5, 1, 1'b0, 1'b1));
      cmp_trip = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R5 flag after two edges", 32'(trip_flag), 32'd0);
      @(negedge clk);
      check("R5 flag after three edges", 32'(trip_flag), 32'd1);
      check("R7 irq with enable", 32'(irq), 32'd1);
      begin
         int lows;
         lows = 0;
         for (int k = 0; k < 10; k++) begin
            if (!core_rst_n) lows++;
            @(negedge clk);
         end
         check("R8 no reset when disabled", 32'(lows), 32'd0);
      end
      cmp_trip = 1'b0;
      cyc(4);
      check("R6 flag sticky", 32'(trip_flag), 32'd1);
      rd_status(v);
      check("R4 status read", v, 32'd1);
      check("R6 flag cleared", 32'(trip_flag), 32'd0);
      check("R7 irq cleared", 32'(irq), 32'd0);

      // R7 interrupt enable off
      wr(mk(5, 1, 1'b0, 1'b0));
      cmp_trip = 1'b1;
      cyc(5);
      check("R7 flag set", 32'(trip_flag), 32'd1);
      check("R7 irq masked", 32'(irq), 32'd0);
      cmp_trip = 1'b0;
      cyc(4);
      rd_status(v);

      // R8 single pulse, exact hold
      wr(mk(5, 1, 1'b1, 1'b0));
      cmp_trip = 1'b1;
      @(negedge clk);
      cmp_trip = 1'b0;
      @(negedge clk);
      check("R8 not yet low", 32'(core_rst_n), 32'd1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R8 held low", 32'(core_rst_n), 32'd0);
      end
      @(negedge clk);
      check("R9 released on clean sample", 32'(core_rst_n), 32'd1);

      // R9 held trip keeps reset low, release timed after trip removal
      cmp_trip = 1'b1;
      cyc(12);
      check("R9 low while trip held", 32'(core_rst_n), 32'd0);
      cmp_trip = 1'b0;
      cyc(5);
      check("R9 low after reload", 32'(core_rst_n), 32'd0);
      @(negedge clk);
      check("R9 released", 32'(core_rst_n), 32'd1);

      // R9 release when sampling switched off
      cmp_trip = 1'b1;
      cyc(4);
      check("R9 low before disable", 32'(core_rst_n), 32'd0);
      wr(mk(5, 0, 1'b1, 1'b0));
      cyc(8);
      check("R9 released when off", 32'(core_rst_n), 32'd1);
      rd_status(v);

      // R5 duty window with trip already synchronized; R2 restart
      cyc(3);
      check("R5 no detect while off", 32'(trip_flag), 32'd0);
      wr(mk(5, 2, 1'b0, 1'b1));
      cyc(31);
      check("R5 no detect before window", 32'(trip_flag), 32'd0);
      @(negedge clk);
      check("R5 detect in window", 32'(trip_flag), 32'd1);
      cmp_trip = 1'b0;
      wr(mk(0, 0, 1'b0, 1'b0));
      cyc(3);
      rd_status(v);
      check("R6 cleared at end", 32'(trip_flag), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule